// File: doc/BRIEF.md
# Reloadable Baud Rate Tick Generator

This block produces baud-rate ticks for two serial channels from the peripheral clock. It runs a 16-bit up-counter. When the counter passes its all-ones value, it reloads from a 16-bit value that software writes one byte at a time. Channel 0 receives every overflow as a one-cycle pulse. Channel 1 receives either the same pulse or every fourth one, chosen by a divide-select bit. The UART still applies its own 16x oversampling, so the channel 0 baud rate is f_clk / (16 × (65536 − reload)).

Software uses a byte-wide write/read port with three addresses: reload low byte, reload high byte, and control. A small state machine with three states sequences the counter:
- `ST_STOPPED`: the counter holds.
- `ST_PRELOAD`: the counter is loaded from the reload value.
- `ST_COUNTING`: the counter increments once per clock and reloads on overflow.

The state machine has these transitions:
- `start`: from `ST_STOPPED` to `ST_PRELOAD` when the run bit is 1.
- `arm`: from `ST_PRELOAD` to `ST_COUNTING` when the run bit is still 1.
- `halt`: from `ST_PRELOAD` or `ST_COUNTING` to `ST_STOPPED` when the run bit is 0.
- `overflow`: the `ST_COUNTING` self-loop that reloads the counter and emits a tick.

Top module: `baud_tick_gen`

## Requirements
- R1: After reset, all registers read 0, both tick outputs are low, and the timer is stopped.
- R2: Address 0 holds the reload low byte and address 1 holds the reload high byte. Both read back the value last written.
- R3: Address 2 is control. Bit 1 is run and bit 0 is divide-select. Bits 7..2 read 0 and ignore writes. Address 3 reads 0.
- R4: While run is 0, no tick is produced on either output, even if the reload value or divide-select changes.
- R5: A write that sets run loads the counter from the reload value R. The first channel 0 tick is then high in the cycle that follows the (65537 − R)th clock edge after the write edge.
- R6: While running, channel 0 ticks come every 65536 − R clocks. Each tick lasts one cycle, except when R = 0xFFFF, where the tick is high every cycle.
- R7: A reload write made while running does not change the period in progress. The new value is used from the next overflow on.
- R8: With divide-select 0, channel 1 equals channel 0 in every cycle.
- R9: With divide-select 1, channel 1 pulses together with every fourth channel 0 tick. The first channel 1 pulse comes with the fourth channel 0 tick after start.
- R10: Clearing run stops both outputs from the next cycle on and clears the divide-by-four phase. A restart therefore counts four fresh overflows before the next channel 1 pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 reload low, 1 reload high, 2 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| tick0 | output | 1 | Channel 0 baud tick |
| tick1 | output | 1 | Channel 1 baud tick, optionally divided by four |

## Verification
A wrong counter value or a missed reload shows up at the ports as a change in the spacing between `tick0` pulses, one period after the fault at the latest. A skipped preload shifts the first tick after a start away from 65537 − R edges. A prescaler that is not cleared or is out of phase moves the first `tick1` after a restart. That error appears within four channel 0 periods. Because reads are combinational, a register fault is visible on `rdata` in the same cycle the address is applied.

// File: rtl/baud_pkg.sv
package baud_pkg;
    typedef enum logic [1:0] {
        ST_STOPPED  = 2'd0,
        ST_PRELOAD  = 2'd1,
        ST_COUNTING = 2'd2
    } cnt_state_e;

    localparam int CTRL_RUN_BIT = 1;
    localparam int CTRL_DIV_BIT = 0;
endpackage

// File: rtl/baud_regs.sv
module baud_regs #(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [CNT_W-1:0]  reload,
    output logic              run,
    output logic              div4
);
    import baud_pkg::*;

    localparam int BYTES = CNT_W / 8;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(BYTES);

    logic [7:0] lane_rd [BYTES];
    logic       run_q, div_q;

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        logic [7:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                q <= 8'h00;
            else if (wr_en && addr == ADDR_W'(b))
                q <= wdata;
        end
        assign reload[b*8 +: 8] = q;
        assign lane_rd[b]       = q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 1'b0;
            div_q <= 1'b0;
        end else if (wr_en && addr == CTRL_ADDR) begin
            run_q <= wdata[CTRL_RUN_BIT];
            div_q <= wdata[CTRL_DIV_BIT];
        end
    end

    always_comb begin
        rdata = 8'h00;
        if (addr == CTRL_ADDR) begin
            rdata[CTRL_RUN_BIT] = run_q;
            rdata[CTRL_DIV_BIT] = div_q;
        end else begin
            for (int b = 0; b < BYTES; b++)
                if (addr == ADDR_W'(b)) rdata = lane_rd[b];
        end
    end

    assign run  = run_q;
    assign div4 = div_q;

    // R3: a control write with any reserved bits leaves only run/div visible
    p_ctrl_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == CTRL_ADDR) |=> (run == $past(wdata[CTRL_RUN_BIT]) && div4 == $past(wdata[CTRL_DIV_BIT])));
endmodule

// File: rtl/baud_counter.sv
module baud_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             ovf
);
    import baud_pkg::*;

    cnt_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_STOPPED;
        else        state_q <= state_d;
    end

    // next state: start, arm, halt, overflow
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED:  if (run)  state_d = ST_PRELOAD;
            ST_PRELOAD:  state_d = run ? ST_COUNTING : ST_STOPPED;
            ST_COUNTING: if (!run) state_d = ST_STOPPED;
            default:     state_d = ST_STOPPED;
        endcase
    end

    // outputs
    always_comb begin
        ovf = (state_q == ST_COUNTING) && run && (count_q == '1);
    end

    // counter datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (run) begin
            if (state_q == ST_PRELOAD)
                count_q <= reload;
            else if (state_q == ST_COUNTING)
                count_q <= (count_q == '1) ? reload : count_q + CNT_W'(1);
        end
    end

    p_preload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PRELOAD && run) |=> (count_q == $past(reload)));

    p_reload_on_ovf_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> (count_q == $past(reload)));

    p_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNTING && run && count_q != '1) |=> (count_q == $past(count_q) + CNT_W'(1)));

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count_q));
endmodule

// File: rtl/baud_quarter.sv
module baud_quarter #(
    parameter int DIV_LOG2 = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic div4,
    input  logic ovf,
    output logic tick_out
);
    logic [DIV_LOG2-1:0] pre_q;
    logic                wrap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pre_q <= '0;
        else if (!run)   pre_q <= '0;
        else if (ovf)    pre_q <= pre_q + DIV_LOG2'(1);
    end

    assign wrap     = ovf && (pre_q == '1);
    assign tick_out = div4 ? wrap : ovf;

    p_pre_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (pre_q == '0));
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen #(
    parameter int CNT_W    = 16,
    parameter int DIV_LOG2 = 2,
    parameter int ADDR_W   = $clog2(CNT_W / 8 + 2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic              tick0,
    output logic              tick1
);
    logic [CNT_W-1:0] reload;
    logic             run, div4, ovf;

    baud_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .reload(reload), .run(run), .div4(div4)
    );

    baud_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run(run), .reload(reload), .ovf(ovf)
    );

    baud_quarter #(.DIV_LOG2(DIV_LOG2)) u_quarter (
        .clk(clk), .rst_n(rst_n), .run(run), .div4(div4), .ovf(ovf), .tick_out(tick1)
    );

    assign tick0 = ovf;

    p_stop_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !run |-> (!tick0 && !tick1));

    p_ch1_pass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !div4 |-> (tick1 == tick0));

    p_ch1_subset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick1 |-> tick0);
endmodule

// File: tb/tb_baud_tick_gen.sv
module tb_baud_tick_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tick0, tick1;

    int tests = 0;
    int fails = 0;
    localparam int LIMIT = 3000;

    // {reload, first-tick latency, period}
    localparam logic [47:0] VEC [4] = '{
        {16'hFFFC, 16'd5,   16'd4},
        {16'hFFF0, 16'd17,  16'd16},
        {16'hFFFF, 16'd2,   16'd1},
        {16'hFF00, 16'd257, 16'd256}
    };

    baud_tick_gen dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .tick0(tick0), .tick1(tick1)
    );

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; #1; d = rdata;
    endtask

    task automatic next_tick(input int which, output int n);
        n = 0;
        do begin
            @(posedge clk); @(negedge clk); n++;
        end while (((which == 0) ? tick0 : tick1) == 1'b0 && n < LIMIT);
    endtask

    task automatic quiet(input int cycles, input string req);
        int seen = 0;
        for (int k = 0; k < cycles; k++) begin
            @(posedge clk); @(negedge clk);
            if (tick0 || tick1) seen++;
        end
        check(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(20 * 150000);
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        int n;
        logic [7:0] d;
        logic [15:0] rl;
        int lat, per;

        repeat (3) @(negedge clk);
        // R1: reset state
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), d);
            check(d == 8'h00, "R1 reset readback", d, 0);
        end
        check(!tick0 && !tick1, "R1 ticks low in reset", tick0, 0);
        rst_n = 1'b1;
        @(negedge clk);
        quiet(10, "R1 no ticks after reset");

        // R2: reload byte registers
        wr(2'd0, 8'hA5); wr(2'd1, 8'h3C);
        rd(2'd0, d); check(d == 8'hA5, "R2 low byte", d, 8'hA5);
        rd(2'd1, d); check(d == 8'h3C, "R2 high byte", d, 8'h3C);

        // R3: control bits, reserved bits, unused address
        wr(2'd2, 8'hFF);
        rd(2'd2, d); check(d == 8'h03, "R3 ctrl readback", d, 3);
        wr(2'd2, 8'hFC);
        rd(2'd2, d); check(d == 8'h00, "R3 reserved ignored", d, 0);
        wr(2'd3, 8'h77);
        rd(2'd3, d); check(d == 8'h00, "R3 addr3 reads 0", d, 0);

        // R4: stopped timer ignores reload / divide changes
        wr(2'd0, 8'hFF); wr(2'd1, 8'hFF); wr(2'd2, 8'h01);
        quiet(20, "R4 stopped no ticks");
        wr(2'd2, 8'h00);

        // Table: R5 latency, R6 period, R8 passthrough, R9 divide
        for (int i = 0; i < 4; i++) begin
            rl  = VEC[i][47:32];
            lat = int'(VEC[i][31:16]);
            per = int'(VEC[i][15:0]);
            wr(2'd0, rl[7:0]); wr(2'd1, rl[15:8]); wr(2'd2, 8'h02);
            next_tick(0, n);
            check(n == lat, "R5 first tick latency", n, lat);
            check(tick1 == 1'b1, "R8 ch1 follows ch0", tick1, 1);
            next_tick(0, n);
            check(n == per, "R6 period", n, per);
            @(posedge clk); @(negedge clk);
            check(tick0 == (per == 1), "R6 tick width", tick0, (per == 1));
            wr(2'd2, 8'h00);
            wr(2'd2, 8'h03);
            next_tick(1, n);
            check(n == lat + 3 * per, "R9 first divided tick", n, lat + 3 * per);
            next_tick(1, n);
            check(n == 4 * per, "R9 divided period", n, 4 * per);
            wr(2'd2, 8'h00);
        end

        // R7: reload write during run takes effect at the next overflow
        wr(2'd0, 8'hF0); wr(2'd1, 8'hFF); wr(2'd2, 8'h02);
        next_tick(0, n);
        next_tick(0, n);
        wr(2'd0, 8'hFC);       // write edge is the overflow edge: old value loaded
        next_tick(0, n);
        check(n == 15, "R7 period in progress unchanged", n + 1, 16);
        next_tick(0, n);
        check(n == 4, "R7 new reload used", n, 4);
        wr(2'd2, 8'h00);

        // R10: stop clears prescaler phase
        wr(2'd2, 8'h03);
        next_tick(0, n);
        next_tick(0, n);
        wr(2'd2, 8'h00);
        quiet(30, "R10 stop silences outputs");
        wr(2'd2, 8'h03);
        next_tick(1, n);
        check(n == 17, "R10 prescaler cleared on restart", n, 17);
        wr(2'd2, 8'h00);

        finish_run();
    end
endmodule